// File: doc/BRIEF.md
# Macroblock YUV 4:2:0 to Packed UYVY Converter

This block receives planar 4:2:0 macroblocks as a stream of 32-byte beats and writes each one into video memory as packed 4:2:2 UYVY words. The words land in a raster frame whose width and height are set in whole 16x16 macroblocks. Each macroblock carries an 8x8 U plane, an 8x8 V plane and four 8x8 luma quadrants. The block stages twelve beats, then emits 128 words, one two-pixel pair per accepted word. Every chroma sample is shared by a 2x2 group of pixels. A destination pointer steps across the frame in macroblock-raster order. A block counter tracks progress, and at frame end the block pulses an interrupt and rearms itself from its registers.

Software writes a control word (frame size and two mode bits) and a base address. Any register write abandons work in flight and restarts the frame. Input uses valid/ready. The block holds `in_ready` low while it is emitting a macroblock, so upstream stalls. Output also uses valid/ready. While `mem_ready` is low, the pending word and its address stay frozen.

Top module: `mb420_uyvy_conv`

## Requirements
- R1: After reset, `in_ready`=1, `mem_valid`=0, `frame_irq`=0, `blk_count`=0 and `fmt_err`=0.
- R2: With `reg_we`=1, `reg_sel`=0 writes the control word: bits [5:0] hold the width in macroblocks minus one, bits [13:8] the height minus one, bit 16 the alternate layout, and bit 24 the 512-byte block size. `reg_sel`=1 writes the base byte address, with bits [4:0] forced to zero. Every register write clears the block count, reloads the pointer from the base, empties the staging buffer and abandons emission. A control write also clears `fmt_err`.
- R3: A beat is taken when `in_valid` and `in_ready` are both high. Byte j of a beat is `in_data[8j+7:8j]`. Twelve beats form bytes 0..383 of a macroblock: 0..63 hold U and 64..127 hold V, each 8x8 row-major. Bytes 128..383 hold four 8x8 row-major luma quadrants in the order top-left, top-right, bottom-left, bottom-right.
- R4: From the cycle after the twelfth beat is taken until the last output word of that macroblock is accepted, `in_ready` is 0, and it is never 1 while `mem_valid` is 1.
- R5: For the pair at even column x and row y (0..15) inside a macroblock, the output word is bits [7:0]=U[x/2+8(y/2)], [15:8]=luma(x,y), [23:16]=V[x/2+8(y/2)] and [31:24]=luma(x+1,y).
- R6: Each macroblock yields 128 words, row by row and left to right within a row. The word for (x,y) goes to byte address P + y*pitch + 2x, where pitch = 32*(width field+1) and P is the current pointer.
- R7: While `mem_valid`=1 and `mem_ready`=0, `mem_valid`, `mem_addr` and `mem_wdata` stay unchanged in the next cycle.
- R8: After each macroblock the pointer advances by 32 bytes. After the last macroblock of a row it advances a further 15*pitch.
- R9: `blk_count` counts the macroblocks finished in the current frame. When it reaches (width+1)*(height+1), `frame_irq` is high for exactly one cycle, the count returns to 0 and the pointer reloads from the base.
- R10: When control bit 16 or bit 24 is set, beats are still accepted (`in_ready`=1) but are discarded. `fmt_err` becomes 1 and stays 1, and no memory write and no count change follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control word, 1 selects base address |
| reg_wdata | input | 32 | Register write data |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat ready |
| in_data | input | 256 | 32-byte input beat |
| mem_valid | output | 1 | Output word valid |
| mem_ready | input | 1 | Memory accepts word |
| mem_addr | output | 24 | Byte address of output word |
| mem_wdata | output | 32 | Packed UYVY word |
| blk_count | output | 13 | Macroblocks done in current frame |
| frame_irq | output | 1 | One-cycle frame completion pulse |
| fmt_err | output | 1 | Sticky unsupported-mode flag |

## Verification
Several rules are checked by assertions on every cycle. Output words stay frozen under memory back-pressure, and input is never ready while a word is pending. Every address is word aligned, the completion pulse lasts one cycle, and the block count stays below the frame total. A discarded beat in an unsupported mode always leaves the error flag set. Other behaviour can only be shown by the bench's scenarios, which compare every written word against an independent frame model. These include the byte interleave across the four luma quadrants, the row stride between macroblock rows, rearming after a frame, abandoning a frame after a base rewrite, and the absence of writes in unsupported modes.

// File: rtl/yuvc_pkg.sv
package yuvc_pkg;
  localparam int BEAT_BYTES = 32;
  localparam int BEAT_W     = BEAT_BYTES * 8;
  localparam int MB_BYTES   = 384;
  localparam int BEATS      = MB_BYTES / BEAT_BYTES;
  localparam int BUF_W      = MB_BYTES * 8;
  localparam int MB_PIX     = 16;
  localparam int WORDS      = MB_PIX * MB_PIX / 2;
  localparam int WORD_IDX_W = $clog2(WORDS);
  localparam int V_OFS      = 64;
  localparam int Y_OFS      = 128;
  localparam int MB_STEP    = MB_PIX * 2;
  localparam int CTRL_W_LSB = 0;
  localparam int CTRL_H_LSB = 8;
  localparam int CTRL_ALT   = 16;
  localparam int CTRL_BIG   = 24;

  typedef enum logic {ST_FILL, ST_EMIT} state_t;

  // luma byte offset: quadrant picked by the top bits of x and y
  function automatic logic [8:0] luma_index(logic [3:0] x, logic [3:0] y);
    return 9'(Y_OFS) + 9'({y[3], x[3], y[2:0], x[2:0]});
  endfunction

  // chroma sample shared by a 2x2 pixel group
  function automatic logic [8:0] chroma_index(logic [2:0] pair, logic [2:0] yhalf);
    return 9'({yhalf, pair});
  endfunction
endpackage

// File: rtl/yuvc_stage.sv
module yuvc_stage
  import yuvc_pkg::*;
#(
  parameter int N_BEATS = BEATS,
  parameter int B_W     = BEAT_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   wr_en,
  input  logic [B_W-1:0]         wr_data,
  output logic                   last_beat,
  output logic [N_BEATS*B_W-1:0] buf_flat
);
  localparam int CW = $clog2(N_BEATS);

  logic [CW-1:0]  beat_q;
  logic [B_W-1:0] slot_q [N_BEATS];

  assign last_beat = (beat_q == CW'(N_BEATS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (flush) beat_q <= '0;
    else if (wr_en) beat_q <= last_beat ? '0 : beat_q + 1'b1;
  end

  for (genvar g = 0; g < N_BEATS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && beat_q == CW'(g)) slot_q[g] <= wr_data;
    end
    assign buf_flat[g*B_W +: B_W] = slot_q[g];
  end

  p_beat_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q < CW'(N_BEATS));
endmodule

// File: rtl/yuvc_track.sv
module yuvc_track
  import yuvc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rearm,
  input  logic [ADDR_W-1:0]    base_nx,
  input  logic [DIM_W-1:0]     wm1,
  input  logic [DIM_W-1:0]     hm1,
  input  logic                 mb_done,
  output logic [ADDR_W-1:0]    ptr,
  output logic [DIM_W+5:0]     pitch,
  output logic [2*DIM_W:0]     count,
  output logic                 irq
);
  localparam int CNT_W = 2*DIM_W + 1;
  localparam int PW    = DIM_W + 6;

  logic [DIM_W:0]   wd, hd;
  logic [CNT_W-1:0] total, cnt_nx;
  logic [DIM_W-1:0] mbx_q;
  logic             row_end;

  assign wd      = {1'b0, wm1} + 1'b1;
  assign hd      = {1'b0, hm1} + 1'b1;
  assign total   = CNT_W'(wd) * CNT_W'(hd);
  assign pitch   = PW'(wd) << 5;
  assign cnt_nx  = count + 1'b1;
  assign row_end = (mbx_q == wm1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      mbx_q <= '0;
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (rearm) begin
        ptr   <= base_nx;
        mbx_q <= '0;
        count <= '0;
      end else if (mb_done) begin
        if (cnt_nx == total) begin
          irq   <= 1'b1;
          count <= '0;
          mbx_q <= '0;
          ptr   <= base_nx;
        end else begin
          count <= cnt_nx;
          if (row_end) begin
            mbx_q <= '0;
            ptr   <= ptr + ADDR_W'(MB_STEP)
                         + ADDR_W'(pitch) * ADDR_W'(MB_PIX - 1);
          end else begin
            mbx_q <= mbx_q + 1'b1;
            ptr   <= ptr + ADDR_W'(MB_STEP);
          end
        end
      end
    end
  end

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_count_below_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count < total);
  p_irq_clears_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> count == '0);
endmodule

// File: rtl/yuvc_pack.sv
module yuvc_pack
  import yuvc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int PW     = 12
) (
  input  logic [BUF_W-1:0]      buf_flat,
  input  logic [WORD_IDX_W-1:0] widx,
  input  logic [ADDR_W-1:0]     ptr,
  input  logic [PW-1:0]         pitch,
  output logic [ADDR_W-1:0]     addr,
  output logic [31:0]           wdata
);
  logic [3:0] row;
  logic [2:0] pair;
  logic [3:0] x0, x1;
  logic [8:0] ci;

  function automatic logic [7:0] pick(logic [BUF_W-1:0] b, logic [8:0] idx);
    return b[{idx, 3'b000} +: 8];
  endfunction

  assign row  = widx[6:3];
  assign pair = widx[2:0];
  assign x0   = {pair, 1'b0};
  assign x1   = {pair, 1'b1};
  assign ci   = chroma_index(pair, row[3:1]);

  assign wdata = {pick(buf_flat, luma_index(x1, row)),
                  pick(buf_flat, ci + 9'(V_OFS)),
                  pick(buf_flat, luma_index(x0, row)),
                  pick(buf_flat, ci)};

  assign addr = ptr + ADDR_W'(row) * ADDR_W'(pitch) + ADDR_W'({pair, 2'b00});
endmodule

// File: rtl/mb420_uyvy_conv.sv
module mb420_uyvy_conv
  import yuvc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DIM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BEAT_W-1:0] in_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [2*DIM_W:0]  blk_count,
  output logic              frame_irq,
  output logic              fmt_err
);
  localparam int PW = DIM_W + 6;

  state_t                state_q;
  logic [WORD_IDX_W-1:0] k_q;
  logic [DIM_W-1:0]      wm1_q, hm1_q;
  logic                  alt_q, big_q;
  logic [ADDR_W-1:0]     base_q, base_nx, ptr;
  logic [PW-1:0]         pitch;
  logic [BUF_W-1:0]      buf_flat;
  logic                  unsup, take, st_wr, last_beat, mb_done;

  assign unsup     = alt_q | big_q;
  assign in_ready  = (state_q == ST_FILL);
  assign mem_valid = (state_q == ST_EMIT);
  assign take      = in_valid & in_ready;
  assign st_wr     = take & ~unsup & ~reg_we;
  assign mb_done   = mem_valid & mem_ready & (k_q == '1) & ~reg_we;
  assign base_nx   = (reg_we && reg_sel) ? {reg_wdata[ADDR_W-1:5], 5'b0} : base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm1_q  <= '0;
      hm1_q  <= '0;
      alt_q  <= 1'b0;
      big_q  <= 1'b0;
      base_q <= '0;
      fmt_err <= 1'b0;
    end else begin
      if (reg_we && !reg_sel) begin
        wm1_q   <= reg_wdata[CTRL_W_LSB +: DIM_W];
        hm1_q   <= reg_wdata[CTRL_H_LSB +: DIM_W];
        alt_q   <= reg_wdata[CTRL_ALT];
        big_q   <= reg_wdata[CTRL_BIG];
        fmt_err <= 1'b0;
      end else if (take && unsup) begin
        fmt_err <= 1'b1;
      end
      if (reg_we && reg_sel) base_q <= base_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      k_q     <= '0;
    end else if (reg_we) begin
      state_q <= ST_FILL;
      k_q     <= '0;
    end else begin
      case (state_q)
        ST_FILL: if (st_wr && last_beat) begin
          state_q <= ST_EMIT;
          k_q     <= '0;
        end
        ST_EMIT: if (mem_ready) begin
          k_q <= k_q + 1'b1;
          if (k_q == '1) state_q <= ST_FILL;
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  yuvc_stage #(.N_BEATS(BEATS), .B_W(BEAT_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (reg_we),
    .wr_en    (st_wr),
    .wr_data  (in_data),
    .last_beat(last_beat),
    .buf_flat (buf_flat)
  );

  yuvc_track #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .rearm  (reg_we),
    .base_nx(base_nx),
    .wm1    (wm1_q),
    .hm1    (hm1_q),
    .mb_done(mb_done),
    .ptr    (ptr),
    .pitch  (pitch),
    .count  (blk_count),
    .irq    (frame_irq)
  );

  yuvc_pack #(.ADDR_W(ADDR_W), .PW(PW)) u_pack (
    .buf_flat(buf_flat),
    .widx    (k_q),
    .ptr     (ptr),
    .pitch   (pitch),
    .addr    (mem_addr),
    .wdata   (mem_wdata)
  );

  p_no_take_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !in_ready);
  p_word_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  p_hold_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !reg_we) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));
  p_err_on_discard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (take && unsup && !reg_we) |=> fmt_err);
  p_no_write_unsup_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (unsup && in_ready && !reg_we) |=> !mem_valid);
endmodule

// File: tb/mb420_uyvy_conv_bench.sv
`timescale 1ns/1ps
module mb420_uyvy_conv_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0]  reg_wdata = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [255:0] in_data = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b1;
  logic [23:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic [12:0]  blk_count;
  logic         frame_irq, fmt_err;

  always #2.5 clk = ~clk;

  mb420_uyvy_conv u_mb420_uyvy_conv (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .blk_count(blk_count),
    .frame_irq(frame_irq), .fmt_err(fmt_err)
  );

  int n_chk = 0, n_fail = 0;
  int gmb = 0;
  int mon_gmb = 0, mon_mb = 0, mon_word = 0;
  int mon_wm1 = 0, mon_hm1 = 0, mon_base = 0;
  int irq_cnt = 0, wr_cnt = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic stall_prev = 1'b0;
  logic [23:0] prev_addr;
  logic [31:0] prev_data;

  // fields: wm1[39:34] hm1[33:28] base[27:4] frames[3:2] ready_mode[1:0]
  localparam logic [39:0] VEC [4] = '{
    {6'd0, 6'd0, 24'h000100, 2'd1, 2'd0},
    {6'd1, 6'd0, 24'h001000, 2'd2, 2'd1},
    {6'd2, 6'd1, 24'h020000, 2'd1, 2'd1},
    {6'd0, 6'd2, 24'h000040, 2'd1, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(int m, int j);
    return 8'((m * 53 + j * 7 + (j >> 4) * 5) ^ (m << 2));
  endfunction

  function automatic int lum(int x, int y);
    return 128 + ((y / 8) * 2 + (x / 8)) * 64 + (x % 8) + (y % 8) * 8;
  endfunction

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
  end

  // output monitor with an independent frame model
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_prev) begin
        chk(mem_valid && mem_addr == prev_addr && mem_wdata == prev_data,
            "R7 hold", {8'(mem_valid), mem_addr, mem_wdata}, {8'd1, prev_addr, prev_data});
      end
      if (mem_valid && mem_ready) begin
        int x, y, ci, pitch, mbx, mby;
        logic [23:0] ea;
        logic [31:0] ed;
        y = mon_word / 8;
        x = (mon_word % 8) * 2;
        ci = x / 2 + 8 * (y / 2);
        pitch = (mon_wm1 + 1) * 32;
        mbx = mon_mb % (mon_wm1 + 1);
        mby = mon_mb / (mon_wm1 + 1);
        ea = 24'(mon_base + mby * 16 * pitch + mbx * 32 + y * pitch + 2 * x);
        ed = {gen(mon_gmb, lum(x + 1, y)), gen(mon_gmb, 64 + ci),
              gen(mon_gmb, lum(x, y)), gen(mon_gmb, ci)};
        chk(mem_addr == ea, "R6 R8 address", 64'(mem_addr), 64'(ea));
        chk(mem_wdata == ed, "R3 R5 word", 64'(mem_wdata), 64'(ed));
        wr_cnt++;
        mon_word++;
        if (mon_word == 128) begin
          mon_word = 0;
          mon_gmb++;
          mon_mb++;
          if (mon_mb == (mon_wm1 + 1) * (mon_hm1 + 1)) mon_mb = 0;
        end
      end
      if (frame_irq) irq_cnt++;
      stall_prev = mem_valid && !mem_ready;
      prev_addr = mem_addr;
      prev_data = mem_wdata;
    end
  end

  task automatic reg_wr(input bit sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cfg(input int wm1, input int hm1, input int base, input logic [31:0] modes);
    reg_wr(1'b0, modes | 32'(wm1) | (32'(hm1) << 8));
    reg_wr(1'b1, 32'(base));
    mon_wm1 = wm1; mon_hm1 = hm1; mon_base = base; mon_mb = 0; mon_word = 0;
  endtask

  task automatic send_beats(input int m, input bit junk);
    for (int b = 0; b < 12; b++) begin
      @(negedge clk);
      for (int j = 0; j < 32; j++) in_data[j*8 +: 8] = gen(m, b * 32 + j);
      in_valid = 1'b1;
      if (junk) chk(in_ready == 1'b1, "R10 ready in bad mode", 64'(in_ready), 64'd1);
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (!junk) chk(in_ready == 1'b0, "R4 stall after block", 64'(in_ready), 64'd0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!(in_ready && !mem_valid)) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(in_ready == 1'b1 && mem_valid == 1'b0, "R1 handshake reset",
        {62'd0, in_ready, mem_valid}, 64'd2);
    chk(frame_irq == 1'b0 && fmt_err == 1'b0 && blk_count == 13'd0, "R1 status reset",
        {48'd0, frame_irq, fmt_err, blk_count}, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < 4; v++) begin
      int wm1, hm1, base, frames, tot, w0;
      wm1 = int'(VEC[v][39:34]); hm1 = int'(VEC[v][33:28]);
      base = int'(VEC[v][27:4]); frames = int'(VEC[v][3:2]);
      tot = (wm1 + 1) * (hm1 + 1);
      rdy_mode = int'(VEC[v][1:0]);
      cfg(wm1, hm1, base, 32'd0);
      irq_cnt = 0; w0 = wr_cnt;
      for (int f = 0; f < frames; f++)
        for (int m = 0; m < tot; m++) begin
          send_beats(gmb, 1'b0);
          gmb++;
        end
      wait_idle();
      chk(irq_cnt == frames, "R9 irq per frame", 64'(irq_cnt), 64'(frames));
      chk(blk_count == 13'd0, "R9 count rearmed", 64'(blk_count), 64'd0);
      chk(wr_cnt - w0 == frames * tot * 128, "R6 word total",
          64'(wr_cnt - w0), 64'(frames * tot * 128));
    end

    // mid-frame base rewrite abandons the frame
    rdy_mode = 0;
    cfg(1, 0, 32'h3000, 32'd0);
    irq_cnt = 0;
    send_beats(gmb, 1'b0); gmb++;
    wait_idle();
    chk(blk_count == 13'd1, "R9 partial count", 64'(blk_count), 64'd1);
    chk(irq_cnt == 0, "R9 no early irq", 64'(irq_cnt), 64'd0);
    reg_wr(1'b1, 32'h5000);
    mon_base = 32'h5000; mon_mb = 0; mon_word = 0;
    chk(blk_count == 13'd0, "R2 rewrite clears count", 64'(blk_count), 64'd0);
    for (int m = 0; m < 2; m++) begin send_beats(gmb, 1'b0); gmb++; end
    wait_idle();
    chk(irq_cnt == 1, "R2 restart from new base", 64'(irq_cnt), 64'd1);

    // unsupported modes: bit 24, then bit 16
    for (int t = 0; t < 2; t++) begin
      int w0;
      cfg(0, 0, 32'h100, (t == 0) ? 32'h0100_0000 : 32'h0001_0000);
      w0 = wr_cnt;
      chk(fmt_err == 1'b0, "R2 error cleared", 64'(fmt_err), 64'd0);
      send_beats(999, 1'b1);
      repeat (150) @(negedge clk);
      chk(fmt_err == 1'b1, "R10 sticky error", 64'(fmt_err), 64'd1);
      chk(wr_cnt == w0, "R10 no writes", 64'(wr_cnt - w0), 64'd0);
      chk(blk_count == 13'd0, "R10 count unchanged", 64'(blk_count), 64'd0);
    end
    reg_wr(1'b0, 32'd0);
    @(negedge clk);
    chk(fmt_err == 1'b0, "R2 control write clears error", 64'(fmt_err), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule